// File: doc/BRIEF.md
# Vector Memory Access Address Sequencer

The sequencer accepts one decoded vector load or store and turns it into a stream of per-element memory requests. Each request carries a byte address, the element number it serves and a replicate flag. A two-bit addressing mode picks one of four address forms: unit-stride, strided, indexed-unordered and indexed-ordered. Only the indexed-ordered form promises an issue order. The other three are free to issue elements in any order, and this implementation issues them from the highest element down to the lowest.

A strided load whose stride is named as the hardwired zero register collapses to a single read, and that read is flagged for replication to every destination element. A zero stride held in any other register still produces one request per element. A store to a region marked non-idempotent is always issued from the lowest element up. When the memory port reports a fault, nothing past the faulting element has been sent, and issue stops at that element.

Requests use a valid/ready handshake. A fault is signalled alongside the handshake of the offending request. The block then reports that element number and holds the report until software acknowledges it.

Top module: `vmem_addr_seq`

## Requirements
- R1: After reset the block is idle: cmd_ready_o=1, req_valid_o=0, fault_o=0, done_o=0.
- R2: The element address depends on the mode. Mode 00 gives base + (i << ew), where ew values 0,1,2,3 mean 1,2,4,8 bytes. Mode 10 gives base + i*stride. Modes 01 and 11 give base + zero-extended idx[i], where index i occupies bits [i*XW +: XW] of cmd_idx_i.
- R3: In mode 11, requests go out in strictly ascending element order, from the start index to vl-1.
- R4: Modes 00, 01 and 10 issue in descending order, from vl-1 down to the start index. This applies to loads and to stores with cmd_idem_i=1.
- R5: A store with cmd_idem_i=0 issues in ascending order in every mode.
- R6: A mode-10 load with cmd_stride_x0_i=1 issues exactly one request, with element = start, address = base and req_repl_o=1. Every other request has req_repl_o=0.
- R7: A mode-10 access with a stride of zero and cmd_stride_x0_i=0 issues every element from start to vl-1, each one at the base address.
- R8: In mode 11 with all indices equal, every element is issued as a separate request to the same address, in ascending order.
- R9: If start >= vl, no request is issued, and done_o pulses in the cycle after the command is accepted.
- R10: done_o pulses for one cycle after the handshake of the final request.
- R11: While req_valid_o=1 and req_ready_i=0, the request address and element hold steady.
- R12: If fault_i is raised during a handshake, no further request is issued. fault_o is then raised with fault_elem_o set to that element and held until fault_ack_i. After that the block returns to idle without raising done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command accepted |
| cmd_mode_i | input | 2 | Addressing mode (00 unit, 01 idx-unordered, 10 strided, 11 idx-ordered) |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_base_i | input | AW | Base address |
| cmd_stride_i | input | AW | Stride value in bytes |
| cmd_stride_x0_i | input | 1 | Stride named as hardwired zero register |
| cmd_ew_i | input | 2 | log2 of element bytes |
| cmd_vl_i | input | IW | Vector length |
| cmd_start_i | input | IW | First element index |
| cmd_idx_i | input | MAXVL*XW | Packed index vector |
| cmd_idem_i | input | 1 | Target region is idempotent |
| req_valid_o | output | 1 | Element request valid |
| req_ready_i | input | 1 | Memory port accepts request |
| req_addr_o | output | AW | Element byte address |
| req_elem_o | output | IW | Element number |
| req_repl_o | output | 1 | Replicate the read to all elements |
| req_store_o | output | 1 | Request is a store |
| fault_i | input | 1 | Fault on the request being handed over |
| fault_o | output | 1 | Fault report pending |
| fault_elem_o | output | IW | Faulting element number |
| fault_ack_i | input | 1 | Fault report acknowledged |
| done_o | output | 1 | Command finished without fault |

## Verification
A corrupted element counter shows up at the very next handshake. The element number and address leave the expected order, or they change while a request is stalled. A wrong direction or collapse decision latched at command accept breaks the first request of the command. A bad end-of-range test either cuts the stream short or runs past it, and the missing or extra element becomes visible together with a missing or early done pulse one cycle after the last handshake. A fault path that keeps running shows an extra request in the cycle after the faulting handshake.

// File: rtl/vmem_seq_pkg.sv
package vmem_seq_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT      = 2'b00,
    MODE_IDX_UNORD = 2'b01,
    MODE_STRIDED   = 2'b10,
    MODE_IDX_ORD   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } seq_state_e;

  typedef struct packed {
    addr_mode_e mode;
    logic       store;
    logic       idem;
    logic       stride_x0;
    logic [1:0] ew;
  } cmd_ctl_t;
endpackage

// File: rtl/vmem_seq_ctrl.sv
module vmem_seq_ctrl
  import vmem_seq_pkg::*;
#(
  parameter int unsigned IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  cmd_ctl_t      cmd_ctl_i,
  input  logic [IW-1:0] cmd_vl_i,
  input  logic [IW-1:0] cmd_start_i,
  output cmd_ctl_t      ctl_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [IW-1:0] elem_o,
  output logic          repl_o,
  input  logic          fault_i,
  output logic          fault_o,
  output logic [IW-1:0] fault_elem_o,
  input  logic          fault_ack_i,
  output logic          done_o
);
  seq_state_e    state_q;
  cmd_ctl_t      ctl_q;
  logic [IW-1:0] cur_q, vl_q, start_q, fault_elem_q;
  logic          asc_q, coll_q, done_q;

  logic accept, empty, coll_w, asc_w, last, hs;

  assign accept = (state_q == ST_IDLE) && cmd_valid_i;
  assign empty  = cmd_start_i >= cmd_vl_i;
  assign coll_w = !cmd_ctl_i.store && (cmd_ctl_i.mode == MODE_STRIDED) && cmd_ctl_i.stride_x0;
  // ascending when ordering is required or when stores must not run past a fault
  assign asc_w  = (cmd_ctl_i.mode == MODE_IDX_ORD) || (cmd_ctl_i.store && !cmd_ctl_i.idem) || coll_w;
  assign last   = coll_q || (asc_q ? (cur_q == vl_q - 1'b1) : (cur_q == start_q));
  assign hs     = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ctl_q        <= '0;
      cur_q        <= '0;
      vl_q         <= '0;
      start_q      <= '0;
      fault_elem_q <= '0;
      asc_q        <= 1'b0;
      coll_q       <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          ctl_q   <= cmd_ctl_i;
          vl_q    <= cmd_vl_i;
          start_q <= cmd_start_i;
          asc_q   <= asc_w;
          coll_q  <= coll_w;
          if (empty) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_RUN;
            cur_q   <= asc_w ? cmd_start_i : cmd_vl_i - 1'b1;
          end
        end
        ST_RUN: if (hs) begin
          if (fault_i) begin
            state_q      <= ST_FAULT;
            fault_elem_q <= cur_q;
          end else if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cur_q <= asc_q ? cur_q + 1'b1 : cur_q - 1'b1;
          end
        end
        ST_FAULT: if (fault_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o  = state_q == ST_IDLE;
  assign req_valid_o  = state_q == ST_RUN;
  assign elem_o       = cur_q;
  assign repl_o       = coll_q;
  assign ctl_o        = ctl_q;
  assign fault_o      = state_q == ST_FAULT;
  assign fault_elem_o = fault_elem_q;
  assign done_o       = done_q;

  assert_hold_elem_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(elem_o));
  assert_ord_ascending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !fault_i && !last && ctl_q.mode == MODE_IDX_ORD |=> elem_o == $past(elem_o) + 1'b1);
  assert_unord_descending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !fault_i && !last && ctl_q.mode != MODE_IDX_ORD && !(ctl_q.store && !ctl_q.idem)
    |=> elem_o == $past(elem_o) - 1'b1);
  assert_stop_after_fault_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && fault_i |=> !req_valid_o && fault_o);
  assert_repl_only_x0_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && repl_o |-> ctl_q.mode == MODE_STRIDED && !ctl_q.store && ctl_q.stride_x0);
  assert_elem_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> elem_o >= start_q && elem_o < vl_q);
  assert_no_done_in_fault_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !done_o && !req_valid_o);
endmodule

// File: rtl/vmem_addr_calc.sv
module vmem_addr_calc
  import vmem_seq_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned XW    = 32,
  parameter int unsigned MAXVL = 16,
  parameter int unsigned IW    = 5
) (
  input  addr_mode_e          mode_i,
  input  logic [1:0]          ew_i,
  input  logic                stride_x0_i,
  input  logic [AW-1:0]       base_i,
  input  logic [AW-1:0]       stride_i,
  input  logic [MAXVL*XW-1:0] idx_vec_i,
  input  logic [IW-1:0]       elem_i,
  output logic [AW-1:0]       addr_o
);
  localparam int unsigned SW = (MAXVL > 1) ? $clog2(MAXVL) : 1;

  logic [XW-1:0] idx_arr [MAXVL];
  for (genvar g = 0; g < MAXVL; g++) begin : g_idx
    assign idx_arr[g] = idx_vec_i[g*XW +: XW];
  end

  logic [AW-1:0] elem_ext, stride_eff, idx_ext, offset;
  logic [XW-1:0] idx_sel;

  assign elem_ext   = AW'(elem_i);
  assign stride_eff = stride_x0_i ? '0 : stride_i;
  assign idx_sel    = idx_arr[elem_i[SW-1:0]];
  assign idx_ext    = AW'(idx_sel);

  always_comb begin
    unique case (mode_i)
      MODE_UNIT:    offset = elem_ext << ew_i;
      MODE_STRIDED: offset = elem_ext * stride_eff;
      default:      offset = idx_ext;
    endcase
  end

  assign addr_o = base_i + offset;
endmodule

// File: rtl/vmem_addr_seq.sv
module vmem_addr_seq
  import vmem_seq_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned XW    = 32,
  parameter int unsigned MAXVL = 16,
  localparam int unsigned IW   = $clog2(MAXVL + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [1:0]          cmd_mode_i,
  input  logic                cmd_store_i,
  input  logic [AW-1:0]       cmd_base_i,
  input  logic [AW-1:0]       cmd_stride_i,
  input  logic                cmd_stride_x0_i,
  input  logic [1:0]          cmd_ew_i,
  input  logic [IW-1:0]       cmd_vl_i,
  input  logic [IW-1:0]       cmd_start_i,
  input  logic [MAXVL*XW-1:0] cmd_idx_i,
  input  logic                cmd_idem_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [AW-1:0]       req_addr_o,
  output logic [IW-1:0]       req_elem_o,
  output logic                req_repl_o,
  output logic                req_store_o,
  input  logic                fault_i,
  output logic                fault_o,
  output logic [IW-1:0]       fault_elem_o,
  input  logic                fault_ack_i,
  output logic                done_o
);
  cmd_ctl_t            cmd_ctl, ctl;
  logic [AW-1:0]       base_q, stride_q;
  logic [MAXVL*XW-1:0] idx_q;
  logic                accept;

  assign cmd_ctl = '{mode: addr_mode_e'(cmd_mode_i), store: cmd_store_i,
                     idem: cmd_idem_i, stride_x0: cmd_stride_x0_i, ew: cmd_ew_i};
  assign accept  = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
    end else if (accept) begin
      base_q   <= cmd_base_i;
      stride_q <= cmd_stride_i;
      idx_q    <= cmd_idx_i;
    end
  end

  vmem_seq_ctrl #(.IW(IW)) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_ctl_i    (cmd_ctl),
    .cmd_vl_i     (cmd_vl_i),
    .cmd_start_i  (cmd_start_i),
    .ctl_o        (ctl),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .elem_o       (req_elem_o),
    .repl_o       (req_repl_o),
    .fault_i      (fault_i),
    .fault_o      (fault_o),
    .fault_elem_o (fault_elem_o),
    .fault_ack_i  (fault_ack_i),
    .done_o       (done_o)
  );

  vmem_addr_calc #(.AW(AW), .XW(XW), .MAXVL(MAXVL), .IW(IW)) addr_i (
    .mode_i      (ctl.mode),
    .ew_i        (ctl.ew),
    .stride_x0_i (ctl.stride_x0),
    .base_i      (base_q),
    .stride_i    (stride_q),
    .idx_vec_i   (idx_q),
    .elem_i      (req_elem_o),
    .addr_o      (req_addr_o)
  );

  assign req_store_o = ctl.store;

  assert_hold_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> $stable(req_addr_o));
  assert_x0_single_base_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_repl_o |-> req_addr_o == base_q);
  assert_idle_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && (req_valid_o || fault_o)));
endmodule

// File: tb/vmem_addr_seq_tb_top.sv
module vmem_addr_seq_tb_top;
  localparam int AW = 32, XW = 32, MAXVL = 16, IW = $clog2(MAXVL + 1);

  typedef struct {
    logic [AW-1:0] addr;
    int            elem;
    bit            repl;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                cmd_valid = 0, cmd_ready;
  logic [1:0]          cmd_mode = 0, cmd_ew = 0;
  logic                cmd_store = 0, cmd_x0 = 0, cmd_idem = 1;
  logic [AW-1:0]       cmd_base = 0, cmd_stride = 0;
  logic [IW-1:0]       cmd_vl = 0, cmd_start = 0;
  logic [MAXVL*XW-1:0] cmd_idx = '0;
  logic                req_valid, req_ready = 0, req_repl, req_store;
  logic [AW-1:0]       req_addr;
  logic [IW-1:0]       req_elem, fault_elem;
  logic                fault_in = 0, fault_out, fault_ack = 0, done;

  vmem_addr_seq #(.AW(AW), .XW(XW), .MAXVL(MAXVL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_mode_i(cmd_mode),
    .cmd_store_i(cmd_store), .cmd_base_i(cmd_base), .cmd_stride_i(cmd_stride),
    .cmd_stride_x0_i(cmd_x0), .cmd_ew_i(cmd_ew), .cmd_vl_i(cmd_vl),
    .cmd_start_i(cmd_start), .cmd_idx_i(cmd_idx), .cmd_idem_i(cmd_idem),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_elem_o(req_elem), .req_repl_o(req_repl), .req_store_o(req_store),
    .fault_i(fault_in), .fault_o(fault_out), .fault_elem_o(fault_elem),
    .fault_ack_i(fault_ack), .done_o(done)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  exp_t  q[$];
  string cur_tag = "";
  int    fault_tgt = -1;
  bit    stall_en = 0;
  int    rdy_cnt = 0;
  bit    prev_stall = 0;
  logic [AW-1:0] prev_addr;
  logic [IW-1:0] prev_elem;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: drives ready/fault and scores each handshake
  always @(negedge clk) begin
    bit rdy;
    exp_t e;
    if (rst_n) begin
      if (prev_stall) begin
        chk(req_valid && req_addr == prev_addr && req_elem == prev_elem, "R11",
            "held request", longint'(req_addr), longint'(prev_addr));
      end
      rdy_cnt++;
      rdy = stall_en ? (rdy_cnt % 3 != 0) : 1'b1;
      req_ready <= rdy;
      fault_in  <= req_valid && rdy && (int'(req_elem) == fault_tgt);
      prev_stall = req_valid && !rdy;
      prev_addr  = req_addr;
      prev_elem  = req_elem;
      if (req_valid && rdy) begin
        if (q.size() == 0) begin
          chk(0, cur_tag, "unexpected request elem", longint'(req_elem), -1);
        end else begin
          e = q.pop_front();
          chk(int'(req_elem) == e.elem, cur_tag, "elem", longint'(req_elem), e.elem);
          chk(req_addr == e.addr, cur_tag, "addr", longint'(req_addr), longint'(e.addr));
          chk(req_repl == e.repl, "R6", "repl flag", longint'(req_repl), e.repl);
        end
      end
    end
  end

  task automatic run_cmd(input string tag, input logic [1:0] mode, input bit store,
                         input logic [AW-1:0] base, input logic [AW-1:0] stride,
                         input bit x0, input logic [1:0] ew, input int vl, input int start,
                         input bit idem, input int ftgt);
    bit asc, coll;
    int lim;
    exp_t e;
    coll = !store && mode == 2'b10 && x0;
    asc  = mode == 2'b11 || (store && !idem) || coll;
    q.delete();
    if (start < vl) begin
      for (int k = 0; k < vl - start; k++) begin
        int i;
        i = asc ? start + k : vl - 1 - k;
        case (mode)
          2'b00:   e.addr = base + (AW'(i) << ew);
          2'b10:   e.addr = base + AW'(i) * (x0 ? '0 : stride);
          default: e.addr = base + AW'(cmd_idx[i*XW +: XW]);
        endcase
        e.elem = i;
        e.repl = coll;
        q.push_back(e);
        if (coll || i == ftgt) break;
      end
    end
    cur_tag   = tag;
    fault_tgt = ftgt;
    @(negedge clk);
    cmd_valid = 1; cmd_mode = mode; cmd_store = store; cmd_base = base;
    cmd_stride = stride; cmd_x0 = x0; cmd_ew = ew; cmd_vl = IW'(vl);
    cmd_start = IW'(start); cmd_idem = idem;
    @(negedge clk);
    cmd_valid = 0;
    if (start >= vl) begin
      chk(done === 1'b1 && req_valid === 1'b0, "R9", "done one cycle after accept",
          longint'(done), 1);
      @(negedge clk);
      chk(done === 1'b0 && cmd_ready === 1'b1, "R9", "done single pulse", longint'(done), 0);
      return;
    end
    lim = 0;
    while (!done && !fault_out && lim < 200) begin
      @(negedge clk);
      lim++;
    end
    if (ftgt >= 0) begin
      chk(fault_out === 1'b1, "R12", "fault raised", longint'(fault_out), 1);
      chk(int'(fault_elem) == ftgt, "R12", "fault element", longint'(fault_elem), ftgt);
      chk(q.size() == 0, "R12", "missing requests before fault", q.size(), 0);
      for (int w = 0; w < 3; w++) begin
        @(negedge clk);
        chk(!req_valid && fault_out && !done, "R12", "quiet while fault pending",
            longint'(req_valid), 0);
      end
      fault_ack = 1;
      @(negedge clk);
      fault_ack = 0;
      chk(cmd_ready === 1'b1 && !fault_out && !done, "R12", "idle after ack",
          longint'(cmd_ready), 1);
    end else begin
      chk(done === 1'b1, "R10", {tag, " done pulse"}, longint'(done), 1);
      chk(q.size() == 0, tag, "requests missing at done", q.size(), 0);
      @(negedge clk);
      chk(done === 1'b0 && !req_valid, "R10", "done one cycle only", longint'(done), 0);
    end
    fault_tgt = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1 && req_valid === 1'b0 && fault_out === 1'b0 && done === 1'b0,
        "R1", "reset state", longint'({cmd_ready, req_valid, fault_out, done}), 8);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && req_valid === 1'b0, "R1", "idle after reset",
        longint'(cmd_ready), 1);

    for (int i = 0; i < MAXVL; i++) cmd_idx[i*XW +: XW] = XW'((i * 37 + 5) % 211) << 2;

    run_cmd("R2 R4 unit load", 2'b00, 0, 32'h1000, 0, 0, 2'd2, 8, 0, 1, -1);
    stall_en = 1;
    run_cmd("R4 unit store idem", 2'b00, 1, 32'h2000, 0, 0, 2'd3, 5, 1, 1, -1);
    run_cmd("R5 unit store nonidem", 2'b00, 1, 32'h3000, 0, 0, 2'd1, 6, 0, 0, -1);
    run_cmd("R2 R4 strided load", 2'b10, 0, 32'h4000, 32'd24, 0, 2'd2, 6, 2, 1, -1);
    run_cmd("R6 x0 stride load", 2'b10, 0, 32'h5000, 32'd0, 1, 2'd2, 8, 3, 1, -1);
    run_cmd("R7 zero stride reg", 2'b10, 0, 32'h6000, 32'd0, 0, 2'd2, 4, 0, 1, -1);
    run_cmd("R5 strided store nonidem", 2'b10, 1, 32'h6100, 32'd12, 0, 2'd2, 5, 1, 0, -1);
    run_cmd("R2 R4 idx unordered load", 2'b01, 0, 32'h7000, 0, 0, 2'd0, 7, 0, 1, -1);
    run_cmd("R3 idx ordered store", 2'b11, 1, 32'h8000, 0, 0, 2'd2, 9, 0, 1, -1);
    for (int i = 0; i < MAXVL; i++) cmd_idx[i*XW +: XW] = 32'h40;
    run_cmd("R8 fifo pop ordered", 2'b11, 0, 32'h9000, 0, 0, 2'd2, 5, 0, 0, -1);
    run_cmd("R9 start equals vl", 2'b00, 0, 32'hA000, 0, 0, 2'd0, 6, 6, 1, -1);
    run_cmd("R9 vl zero", 2'b11, 0, 32'hA000, 0, 0, 2'd0, 0, 0, 1, -1);
    run_cmd("R12 fault nonidem store", 2'b10, 1, 32'hB000, 32'd8, 0, 2'd3, 8, 0, 0, 3);
    run_cmd("R12 fault ordered load", 2'b11, 0, 32'hC000, 0, 0, 2'd2, 6, 1, 1, 2);
    stall_en = 0;
    run_cmd("R2 full length unit", 2'b00, 0, 32'hD000, 0, 0, 2'd1, 16, 0, 1, -1);
    run_cmd("R7 zero stride store", 2'b10, 1, 32'hE000, 32'd0, 0, 2'd0, 3, 0, 1, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule